// File: doc/BRIEF.md
# Correlating Two-Bit Branch Direction Predictor

This block predicts whether a conditional branch will be taken. A table, indexed directly by low bits of the branch PC with no tag check, holds a group of four two-bit saturating counters for each index. A two-bit global history of the most recent resolved outcomes selects one counter of the indexed group. The selected counter's upper bit is the prediction.

The fetch stage presents a PC on the lookup port and reads a taken/not-taken answer in the same cycle. When a branch resolves, the execute stage presents its PC and real outcome on the update port. At the next clock edge the selected counter moves one step toward the outcome and the outcome is shifted into the history. A lookup in the same cycle as an update sees the state from before that update.

Top module: `corr_bp`

## Requirements
- R1: After reset every counter holds 01 and the history holds 00, so every lookup predicts not taken until an update changes state.
- R2: On a clock edge with `up_valid` high, the counter selected by index `up_pc[INDEX_BITS+1:2]` and the current history rises by one when `up_taken` is 1 and falls by one when it is 0.
- R3: A counter at 11 stays at 11 on a taken update, and a counter at 00 stays at 00 on a not-taken update.
- R4: `lk_taken` is the upper bit of the selected counter: 10 and 11 predict taken, 00 and 01 predict not taken.
- R5: On each update the history shifts left by one and `up_taken` enters at bit 0.
- R6: The four history values select four independent counters for the same table index; training under one history leaves the other three counters unchanged.
- R7: Lookup and update use PC bits [INDEX_BITS+1:2] as the index; bits [1:0] and bits above INDEX_BITS+1 are ignored, so PCs differing only there share counters.
- R8: `lk_taken` follows `lk_pc` without a clock edge; when lookup and update hit the same counter in one cycle, the lookup reports the value from before the update.
- R9: With `up_valid` low, neither counters nor history change, whatever `up_pc` and `up_taken` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | PC of the branch being fetched |
| lk_taken | output | 1 | Predicted direction, 1 = taken |
| up_valid | input | 1 | A resolved branch is presented this cycle |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome, 1 = taken |

## Verification
A steady always-taken stream on one branch shows the counter climbing and saturating, and a following not-taken burst shows the two-step hysteresis before the prediction flips. An alternating taken/not-taken stream on one PC makes the history alternate, so correct predictions appear only when the four counters per entry are kept apart. PCs that differ only in the low two bits or above the index bits tell apart the correct index slice from a wrong one, and cycles where lookup and update name the same entry tell old-value lookup from bypassed lookup. A long pseudo-random stream of mixed PCs, outcomes and idle update cycles, checked each cycle against a behavioural model, covers the remaining combinations.

// File: rtl/corr_bp.sv
module corr_bp #(
  parameter int PC_W       = 32,
  parameter int INDEX_BITS = 6,
  parameter int HIST_BITS  = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int SLOT_BITS = INDEX_BITS + HIST_BITS;
  localparam int SLOTS     = 1 << SLOT_BITS;

  logic [1:0]           ctr [SLOTS];
  logic [HIST_BITS-1:0] hist;
  logic [1:0]           up_new;

  wire [SLOT_BITS-1:0] lk_slot = {lk_pc[INDEX_BITS+1:2], hist};
  wire [SLOT_BITS-1:0] up_slot = {up_pc[INDEX_BITS+1:2], hist};
  wire [1:0]           up_old  = ctr[up_slot];
  wire unused_pc_bits = ^{lk_pc[PC_W-1:INDEX_BITS+2], lk_pc[1:0],
                          up_pc[PC_W-1:INDEX_BITS+2], up_pc[1:0]};

  assign lk_taken = ctr[lk_slot][1];

  always_comb begin
    if (up_taken) up_new = (up_old == 2'b11) ? up_old : up_old + 2'd1;
    else          up_new = (up_old == 2'b00) ? up_old : up_old - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) ctr[i] <= 2'b01;
      hist <= '0;
    end else if (up_valid) begin
      ctr[up_slot] <= up_new;
      hist         <= HIST_BITS'({hist, up_taken});
    end
  end

  // R2: one step up on taken, one step down on not taken
  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_taken && up_old != 2'b11 |=> ctr[$past(up_slot)] == $past(up_old) + 2'd1);
  a_r2_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_taken && up_old != 2'b00 |=> ctr[$past(up_slot)] == $past(up_old) - 2'd1);
  // R3: saturation at both ends
  a_r3_sat_high: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && up_taken && up_old == 2'b11 |=> ctr[$past(up_slot)] == 2'b11);
  a_r3_sat_low: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_taken && up_old == 2'b00 |=> ctr[$past(up_slot)] == 2'b00);
  // R5: outcome enters history at bit 0
  a_r5_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> hist[0] == $past(up_taken));
  // R9: idle update port leaves history alone
  a_r9_hist_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !up_valid |=> $stable(hist));
endmodule

// File: tb/corr_bp_bench.sv
module corr_bp_bench;
  localparam int PERIOD = 10;
  localparam int IDXB   = 6;

  logic        clk = 0;
  logic        rst_n = 0;
  logic [31:0] lk_pc = 0;
  logic        lk_taken;
  logic        up_valid = 0;
  logic [31:0] up_pc = 0;
  logic        up_taken = 0;

  int total = 0;
  int bad = 0;
  int mcnt [256];
  int mhist = 0;
  bit finished = 0;

  corr_bp u_corr_bp (.clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
                     .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  always #(PERIOD/2) clk = ~clk;

  function automatic int slot(input logic [31:0] pc);
    return (((pc >> 2) & ((1 << IDXB) - 1)) << 2) | mhist;
  endfunction

  task automatic check(input string tag, input logic got, input logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: lk_taken=%0b expected=%0b (lk_pc=%h)", tag, got, exp, lk_pc);
    end
  endtask

  // drive one cycle, compare lookup before the edge, then advance the model
  task automatic step(input string tag, input logic [31:0] lpc, input logic uv,
                      input logic [31:0] upc, input logic ut);
    @(negedge clk);
    lk_pc = lpc; up_valid = uv; up_pc = upc; up_taken = ut;
    #1;
    check(tag, lk_taken, mcnt[slot(lpc)] >= 2);
    @(posedge clk);
    if (uv) begin
      int s = slot(upc);
      if (ut && mcnt[s] < 3) mcnt[s]++;
      else if (!ut && mcnt[s] > 0) mcnt[s]--;
      mhist = ((mhist << 1) | int'(ut)) & 3;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr = 32'h1234_5678;
    for (int i = 0; i < 256; i++) mcnt[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1: reset state predicts not taken everywhere
    for (int i = 0; i < 16; i++) step("R1", 32'(i * 52), 0, 0, 0);

    // R2 R4 R3: train one branch taken, saturate, then hysteresis
    for (int i = 0; i < 8; i++) step("R2_R4_R3", 32'h100, 1, 32'h100, 1);
    for (int i = 0; i < 4; i++) step("R3_R4", 32'h100, 1, 32'h100, 0);
    for (int i = 0; i < 6; i++) step("R3", 32'h100, 1, 32'h100, 0);

    // R5 R6: alternating outcomes separate counters by history
    for (int i = 0; i < 16; i++) step("R5_R6", 32'h200, 1, 32'h200, i[0]);
    for (int i = 0; i < 4; i++) step("R6", 32'h200, 0, 0, 0);

    // R7: aliasing through ignored PC bits
    for (int i = 0; i < 6; i++) step("R7", 32'h303, 1, 32'h300 + 32'(4 << IDXB), 1);
    step("R7", 32'h300, 0, 0, 0);
    step("R7", 32'hFFFF_F301, 0, 0, 0);

    // R8: same-cycle lookup and update see old value
    for (int i = 0; i < 6; i++) step("R8", 32'h400, 1, 32'h400, 1);
    for (int i = 0; i < 6; i++) step("R8", 32'h400, 1, 32'h400, 0);

    // R9: idle update port with live-looking data has no effect
    for (int i = 0; i < 8; i++) step("R9", 32'h100, 0, 32'h100, 1);
    step("R9", 32'h400, 0, 32'h400, 1);

    // mixed stream
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R2_R6_mixed", {22'd0, lfsr[9:0]} & 32'h1F0, lfsr[12] | lfsr[13],
           {22'd0, lfsr[22:13]} & 32'h1F3, lfsr[25]);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule